// File: doc/BRIEF.md
# Keyboard Device Command Responder

This block plays the part of a PC keyboard answering the host. The controller's data port hands it one byte at a time on `cmd_valid`/`cmd_byte`. The block decodes each byte either as a new command or as the parameter that an earlier command asked for. It writes its answers into a small response queue. The queue's head drives the controller output buffer (`rsp_valid`/`rsp_byte`), and the host takes a byte away by pulsing `rsp_pop`.

Some answers are held back until the host has read what came before them. The identify command gives its two ID bytes one host read apart. The reset command gives its self-test code only after its acknowledge has been read. The block also keeps the settings the host can program: the scan-code set, the typematic byte, the enable flag and the three LED lines.

Top module: `kbd_cmd_responder`

## Requirements
- R1: After reset the queue is empty, `scan_set` is 0x01, `typematic` is 0x23, `kbd_enabled` is 1, `leds` is 0 and nothing is pending. A byte pushed into the queue on one clock edge is visible at `rsp_byte` after that edge.
- R2: An accepted command or parameter is answered with 0xFA. A command byte outside the supported set is answered with 0xFE and changes no setting.
- R3: Command 0xED is answered with 0xFA. The next byte is an LED parameter: bit 0 drives `leds[0]` (scroll), bit 1 drives `leds[1]` (num) and bit 2 drives `leds[2]` (caps). The parameter is answered with another 0xFA.
- R4: Command 0xEE is answered with the single byte 0xEE and no acknowledge.
- R5: Command 0xF0 is answered with 0xFA and its parameter with another 0xFA. A non-zero parameter becomes `scan_set`. A zero parameter leaves the set unchanged and queues the current set number after the 0xFA.
- R6: Command 0xF3 is answered with 0xFA. Its parameter is stored in `typematic` and answered with 0xFA.
- R7: Command 0xF2 is answered with 0xFA. The next host read of a queued byte queues 0x83, and the read after that queues 0xAB.
- R8: Command 0xFF is answered with 0xFA. The next host read of a queued byte queues the self-test code 0xAA.
- R9: Command 0xF4 sets `kbd_enabled`. Command 0xF6 restores the defaults of R1 except `leds`. Command 0xF5 does the same and clears `kbd_enabled`. Both 0xF5 and 0xF6 also cancel any pending identify or self-test byte. All three commands answer 0xFA.
- R10: Commands 0xF7 to 0xFA answer 0xFA. Commands 0xFB to 0xFD answer 0xFA and then wait for one byte. That byte clears the wait and is decoded as a fresh command.
- R11: Command 0xFE queues again the byte most recently read by the host. If no byte has been read since reset, it queues 0x00. A read in the same cycle counts as most recent.
- R12: The queue keeps FIFO order and holds DEPTH bytes (default 8). Bytes that arrive while it is full are discarded. A `rsp_pop` while the queue is empty has no effect and does not advance a pending sequence.
- R13: When a host read and a command byte arrive in the same cycle, the deferred byte that the read releases is queued ahead of the command's answer. The scan-set query value is always queued right after its 0xFA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A host byte is offered this cycle |
| cmd_byte | input | 8 | Command or parameter byte |
| rsp_pop | input | 1 | Host reads the queue head this cycle |
| rsp_valid | output | 1 | Queue holds at least one byte |
| rsp_byte | output | 8 | Byte at the queue head |
| scan_set | output | 8 | Current scan-code set number |
| typematic | output | 8 | Stored typematic setting |
| kbd_enabled | output | 1 | Keyboard enable flag |
| leds | output | 3 | {caps, num, scroll} indicator lines |

## Verification
A host read that releases a deferred identify or self-test byte can land in the same cycle as a new command byte. The queue then takes up to three bytes at once while it also shifts out its head. The bench provokes this by driving `rsp_pop` and `cmd_valid` together, once with the echo command and once with a scan-set query parameter. It judges the result purely by the order in which the bytes come out of the queue afterwards. A reference model in the bench predicts that order: it applies the read first, then the command.

// File: rtl/kbd_resp_pkg.sv
`timescale 1ns/1ps
package kbd_resp_pkg;
  localparam int BYTE_W    = 8;
  localparam int NUM_LANES = 3; // 0: deferred, 1: primary reply, 2: query value

  localparam logic [7:0] RSP_ACK      = 8'hFA;
  localparam logic [7:0] RSP_ERR      = 8'hFE;
  localparam logic [7:0] RSP_ECHO     = 8'hEE;
  localparam logic [7:0] RSP_ID_HI    = 8'h83;
  localparam logic [7:0] RSP_ID_LO    = 8'hAB;
  localparam logic [7:0] RSP_SELFTEST = 8'hAA;
  localparam logic [7:0] DEF_SCAN     = 8'h01;
  localparam logic [7:0] DEF_TYPEMAT  = 8'h23;

  typedef enum logic [2:0] {PW_NONE, PW_LED, PW_SCAN, PW_RATE, PW_KEY} pwait_e;
  typedef enum logic [1:0] {RS_NONE, RS_ID_HI, RS_ID_LO, RS_SELFTEST} rseq_e;
  typedef enum logic [3:0] {
    K_LED, K_ECHO, K_SCAN, K_IDENT, K_RATE, K_ENABLE, K_DEF_OFF,
    K_DEFAULT, K_PLAIN, K_KEYPARAM, K_RESEND, K_RESET, K_BAD
  } cmd_kind_e;

  function automatic cmd_kind_e classify(input logic [7:0] b);
    case (b) inside
      8'hED:          return K_LED;
      8'hEE:          return K_ECHO;
      8'hF0:          return K_SCAN;
      8'hF2:          return K_IDENT;
      8'hF3:          return K_RATE;
      8'hF4:          return K_ENABLE;
      8'hF5:          return K_DEF_OFF;
      8'hF6:          return K_DEFAULT;
      [8'hF7:8'hFA]:  return K_PLAIN;
      [8'hFB:8'hFD]:  return K_KEYPARAM;
      8'hFE:          return K_RESEND;
      8'hFF:          return K_RESET;
      default:        return K_BAD;
    endcase
  endfunction

  function automatic logic [7:0] first_reply(input cmd_kind_e k, input logic [7:0] last);
    case (k)
      K_ECHO:   return RSP_ECHO;
      K_RESEND: return last;
      K_BAD:    return RSP_ERR;
      default:  return RSP_ACK;
    endcase
  endfunction
endpackage

// File: rtl/kbd_cmd_decode.sv
`timescale 1ns/1ps
module kbd_cmd_decode
  import kbd_resp_pkg::*;
(
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cmd_valid,
  input  logic [BYTE_W-1:0]               cmd_byte,
  input  logic                            rd_fire,
  input  logic [BYTE_W-1:0]               rd_byte,
  output logic [NUM_LANES-1:0]            lane_v,
  output logic [NUM_LANES-1:0][BYTE_W-1:0] lane_d,
  output logic [BYTE_W-1:0]               scan_set,
  output logic [BYTE_W-1:0]               typematic,
  output logic                            kbd_enabled,
  output logic [2:0]                      leds,
  output logic                            cmd_fresh,
  output logic                            wait_led,
  output logic                            selftest_pending
);
  pwait_e            wait_q, wait_n;
  rseq_e             seq_q, seq_n;
  logic [BYTE_W-1:0] scan_q, scan_n, typ_q, typ_n, last_q, last_n;
  logic              en_q, en_n;
  logic [2:0]        leds_q, leds_n;
  cmd_kind_e         kind;

  assign cmd_fresh = (wait_q == PW_NONE) || (wait_q == PW_KEY);
  assign kind      = classify(cmd_byte);

  always_comb begin
    wait_n = wait_q;
    seq_n  = seq_q;
    scan_n = scan_q;
    typ_n  = typ_q;
    en_n   = en_q;
    leds_n = leds_q;
    last_n = rd_fire ? rd_byte : last_q;
    lane_v = '0;
    lane_d = '0;
    // deferred reply released by a host read
    if (rd_fire) begin
      case (seq_q)
        RS_ID_HI:    begin lane_v[0] = 1'b1; lane_d[0] = RSP_ID_HI;    seq_n = RS_ID_LO; end
        RS_ID_LO:    begin lane_v[0] = 1'b1; lane_d[0] = RSP_ID_LO;    seq_n = RS_NONE;  end
        RS_SELFTEST: begin lane_v[0] = 1'b1; lane_d[0] = RSP_SELFTEST; seq_n = RS_NONE;  end
        default: ;
      endcase
    end
    if (cmd_valid) begin
      wait_n    = PW_NONE;
      lane_v[1] = 1'b1;
      lane_d[1] = RSP_ACK;
      if (!cmd_fresh) begin
        case (wait_q)
          PW_LED:  leds_n = cmd_byte[2:0];
          PW_SCAN: begin
            if (cmd_byte == '0) begin
              lane_v[2] = 1'b1;
              lane_d[2] = scan_q;
            end else begin
              scan_n = cmd_byte;
            end
          end
          PW_RATE: typ_n = cmd_byte;
          default: ;
        endcase
      end else begin
        lane_d[1] = first_reply(kind, last_n);
        case (kind)
          K_LED:      wait_n = PW_LED;
          K_SCAN:     wait_n = PW_SCAN;
          K_RATE:     wait_n = PW_RATE;
          K_KEYPARAM: wait_n = PW_KEY;
          K_IDENT:    seq_n  = RS_ID_HI;
          K_RESET:    seq_n  = RS_SELFTEST;
          K_ENABLE:   en_n   = 1'b1;
          K_DEF_OFF, K_DEFAULT: begin
            scan_n = DEF_SCAN;
            typ_n  = DEF_TYPEMAT;
            en_n   = (kind == K_DEFAULT);
            seq_n  = RS_NONE;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wait_q <= PW_NONE;
      seq_q  <= RS_NONE;
      scan_q <= DEF_SCAN;
      typ_q  <= DEF_TYPEMAT;
      en_q   <= 1'b1;
      leds_q <= '0;
      last_q <= '0;
    end else begin
      wait_q <= wait_n;
      seq_q  <= seq_n;
      scan_q <= scan_n;
      typ_q  <= typ_n;
      en_q   <= en_n;
      leds_q <= leds_n;
      last_q <= last_n;
    end
  end

  assign scan_set         = scan_q;
  assign typematic        = typ_q;
  assign kbd_enabled      = en_q;
  assign leds             = leds_q;
  assign wait_led         = (wait_q == PW_LED);
  assign selftest_pending = (seq_q == RS_SELFTEST);
endmodule

// File: rtl/kbd_resp_queue.sv
`timescale 1ns/1ps
module kbd_resp_queue #(
  parameter int DEPTH = 8,
  parameter int LANES = 3,
  parameter int W     = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [LANES-1:0]          push_v,
  input  logic [LANES-1:0][W-1:0]   push_d,
  input  logic                      pop,
  output logic                      head_valid,
  output logic [W-1:0]              head_data,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                      drop
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem_q [DEPTH];
  logic [W-1:0]  mem_n [DEPTH];
  logic [CW-1:0] cnt_q, pos;
  logic          pop_eff;

  assign pop_eff = pop && (cnt_q != '0);

  always_comb begin
    mem_n = mem_q;
    pos   = cnt_q;
    drop  = 1'b0;
    if (pop_eff) begin
      for (int i = 0; i < DEPTH - 1; i++) mem_n[i] = mem_q[i+1];
      pos = cnt_q - CW'(1);
    end
    for (int k = 0; k < LANES; k++) begin
      if (push_v[k]) begin
        if (pos < CW'(DEPTH)) begin
          mem_n[pos[AW-1:0]] = push_d[k];
          pos = pos + CW'(1);
        end else begin
          drop = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      cnt_q <= pos;
      mem_q <= mem_n;
    end
  end

  assign head_valid = (cnt_q != '0);
  assign head_data  = mem_q[0];
  assign count      = cnt_q;
endmodule

// File: rtl/kbd_cmd_responder.sv
`timescale 1ns/1ps
module kbd_cmd_responder
  import kbd_resp_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_byte,
  input  logic       rsp_pop,
  output logic       rsp_valid,
  output logic [7:0] rsp_byte,
  output logic [7:0] scan_set,
  output logic [7:0] typematic,
  output logic       kbd_enabled,
  output logic [2:0] leds
);
  localparam int CW = $clog2(DEPTH + 1);

  // named internal events for the checker
  logic [NUM_LANES-1:0]             push_v;
  logic [NUM_LANES-1:0][BYTE_W-1:0] push_d;
  logic                             rd_fire;
  logic                             queue_drop;
  logic [CW-1:0]                    rsp_count;
  logic                             cmd_fresh, wait_led, selftest_pending;

  assign rd_fire = rsp_pop && rsp_valid;

  kbd_cmd_decode dec_i (
    .clk              (clk),
    .rst_n            (rst_n),
    .cmd_valid        (cmd_valid),
    .cmd_byte         (cmd_byte),
    .rd_fire          (rd_fire),
    .rd_byte          (rsp_byte),
    .lane_v           (push_v),
    .lane_d           (push_d),
    .scan_set         (scan_set),
    .typematic        (typematic),
    .kbd_enabled      (kbd_enabled),
    .leds             (leds),
    .cmd_fresh        (cmd_fresh),
    .wait_led         (wait_led),
    .selftest_pending (selftest_pending)
  );

  kbd_resp_queue #(.DEPTH(DEPTH), .LANES(NUM_LANES), .W(BYTE_W)) q_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_v     (push_v),
    .push_d     (push_d),
    .pop        (rsp_pop),
    .head_valid (rsp_valid),
    .head_data  (rsp_byte),
    .count      (rsp_count),
    .drop       (queue_drop)
  );
endmodule

// File: rtl/kbd_cmd_responder_chk.sv
`timescale 1ns/1ps
module kbd_cmd_responder_chk #(
  parameter int DEPTH = 8
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          cmd_valid,
  input logic [7:0]                    cmd_byte,
  input logic                          rsp_pop,
  input logic                          rsp_valid,
  input logic [7:0]                    rsp_byte,
  input logic [7:0]                    scan_set,
  input logic [7:0]                    typematic,
  input logic                          kbd_enabled,
  input logic [2:0]                    leds,
  input logic                          cmd_fresh,
  input logic                          wait_led,
  input logic                          selftest_pending,
  input logic [2:0]                    push_v,
  input logic [$clog2(DEPTH+1)-1:0]    rsp_count
);
  AST_DEFAULTS_RESTORED: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_fresh && cmd_byte == 8'hF6 |=> scan_set == 8'h01 && typematic == 8'h23 && kbd_enabled); // R9

  AST_DISABLE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_fresh && cmd_byte == 8'hF5 |=> !kbd_enabled); // R9

  AST_LED_PARAM: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && wait_led |=> leds == $past(cmd_byte[2:0])); // R3

  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_count == DEPTH && !rsp_pop |=> rsp_count == DEPTH && $stable(rsp_byte)); // R12

  AST_EMPTY_POP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid && push_v == '0 |=> !rsp_valid); // R12

  AST_SELFTEST_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_pop && rsp_valid && selftest_pending && rsp_count == 1 && !cmd_valid
    |=> rsp_valid && rsp_byte == 8'hAA); // R8
endmodule

bind kbd_cmd_responder kbd_cmd_responder_chk #(.DEPTH(DEPTH)) chk_i (
  .clk              (clk),
  .rst_n            (rst_n),
  .cmd_valid        (cmd_valid),
  .cmd_byte         (cmd_byte),
  .rsp_pop          (rsp_pop),
  .rsp_valid        (rsp_valid),
  .rsp_byte         (rsp_byte),
  .scan_set         (scan_set),
  .typematic        (typematic),
  .kbd_enabled      (kbd_enabled),
  .leds             (leds),
  .cmd_fresh        (cmd_fresh),
  .wait_led         (wait_led),
  .selftest_pending (selftest_pending),
  .push_v           (push_v),
  .rsp_count        (rsp_count)
);

// File: tb/kbd_cmd_responder_tb_top.sv
`timescale 1ns/1ps
module kbd_cmd_responder_tb_top;
  localparam int DEPTH = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [7:0] cmd_byte = '0;
  logic       rsp_pop = 1'b0;
  logic       rsp_valid, kbd_enabled;
  logic [7:0] rsp_byte, scan_set, typematic;
  logic [2:0] leds;

  int checks = 0;
  int errors = 0;

  // reference model state
  logic [7:0] expq[$];
  int         mwait = 0;  // 0 none, 1 led, 2 scan, 3 rate, 4 key
  int         mseq  = 0;  // 0 none, 1 id hi, 2 id lo, 3 self-test
  logic [7:0] mscan = 8'h01, mtyp = 8'h23, mlast = 8'h00;
  logic       men = 1'b1;
  logic [2:0] mleds = 3'b000;

  always #4 clk = ~clk;

  kbd_cmd_responder #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .rsp_pop(rsp_pop), .rsp_valid(rsp_valid), .rsp_byte(rsp_byte),
    .scan_set(scan_set), .typematic(typematic), .kbd_enabled(kbd_enabled), .leds(leds)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic qpush(input logic [7:0] b);
    if (expq.size() < DEPTH) expq.push_back(b);
  endtask

  task automatic model_fresh(input logic [7:0] b);
    if (b == 8'hED)      begin qpush(8'hFA); mwait = 1; end
    else if (b == 8'hEE) qpush(8'hEE);
    else if (b == 8'hF0) begin qpush(8'hFA); mwait = 2; end
    else if (b == 8'hF2) begin qpush(8'hFA); mseq = 1; end
    else if (b == 8'hF3) begin qpush(8'hFA); mwait = 3; end
    else if (b == 8'hF4) begin qpush(8'hFA); men = 1'b1; end
    else if (b == 8'hF5 || b == 8'hF6) begin
      qpush(8'hFA); mscan = 8'h01; mtyp = 8'h23; men = (b == 8'hF6); mseq = 0;
    end
    else if (b >= 8'hF7 && b <= 8'hFA) qpush(8'hFA);
    else if (b >= 8'hFB && b <= 8'hFD) begin qpush(8'hFA); mwait = 4; end
    else if (b == 8'hFE) qpush(mlast);
    else if (b == 8'hFF) begin qpush(8'hFA); mseq = 3; end
    else qpush(8'hFE);
  endtask

  task automatic model_cmd(input logic [7:0] b);
    int w;
    w = mwait;
    mwait = 0;
    if (w == 1)      begin mleds = b[2:0]; qpush(8'hFA); end
    else if (w == 2) begin qpush(8'hFA); if (b == 8'h00) qpush(mscan); else mscan = b; end
    else if (w == 3) begin mtyp = b; qpush(8'hFA); end
    else model_fresh(b);
  endtask

  // driver + monitor: one clock, optional read and optional command
  task automatic step(input bit dcmd, input logic [7:0] b, input bit drd, input string tag);
    logic [7:0] want;
    if (drd) begin
      if (expq.size() > 0) begin
        want = expq.pop_front();
        chk(tag, {7'b0, rsp_valid}, 8'h01);
        chk(tag, rsp_byte, want);
        mlast = want;
        if (mseq == 1)      begin qpush(8'h83); mseq = 2; end
        else if (mseq == 2) begin qpush(8'hAB); mseq = 0; end
        else if (mseq == 3) begin qpush(8'hAA); mseq = 0; end
      end else begin
        chk(tag, {7'b0, rsp_valid}, 8'h00);
      end
    end
    if (dcmd) model_cmd(b);
    cmd_valid = dcmd;
    cmd_byte  = b;
    rsp_pop   = drd;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    rsp_pop   = 1'b0;
    chk(tag, scan_set, mscan);
    chk(tag, typematic, mtyp);
    chk(tag, {7'b0, kbd_enabled}, {7'b0, men});
    chk(tag, {5'b0, leds}, {5'b0, mleds});
    chk(tag, {7'b0, rsp_valid}, {7'b0, (expq.size() != 0)});
    if (expq.size() != 0) chk(tag, rsp_byte, expq[0]);
  endtask

  task automatic send(input logic [7:0] b, input string tag);
    step(1'b1, b, 1'b0, tag);
  endtask

  task automatic rd(input string tag);
    step(1'b0, 8'h00, 1'b1, tag);
  endtask

  task automatic drain(input string tag);
    while (expq.size() != 0) rd(tag);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk("R1 valid", {7'b0, rsp_valid}, 8'h00);
    chk("R1 scan", scan_set, 8'h01);
    chk("R1 typematic", typematic, 8'h23);
    chk("R1 enable", {7'b0, kbd_enabled}, 8'h01);
    chk("R1 leds", {5'b0, leds}, 8'h00);

    send(8'hF4, "R2 ack"); drain("R2 ack");
    send(8'h55, "R2 bad"); drain("R2 bad");
    send(8'h00, "R2 bad zero"); drain("R2 bad zero");

    send(8'hED, "R3"); rd("R3"); send(8'h05, "R3"); drain("R3");
    send(8'hED, "R3"); send(8'hFA, "R3"); drain("R3");

    send(8'hEE, "R4"); drain("R4");

    send(8'hF0, "R5"); send(8'h03, "R5"); drain("R5");
    send(8'hF0, "R5"); send(8'h00, "R5"); drain("R5");

    send(8'hF3, "R6"); send(8'h5A, "R6"); drain("R6");

    send(8'hF2, "R7"); rd("R7"); rd("R7"); rd("R7"); rd("R7 empty");

    send(8'hFF, "R8"); drain("R8"); rd("R8 empty");

    send(8'hF5, "R9 disable"); drain("R9");
    send(8'hF0, "R9"); send(8'h02, "R9"); send(8'hF3, "R9"); send(8'h11, "R9");
    send(8'hF4, "R9 enable"); send(8'hF6, "R9 default"); drain("R9");
    send(8'hF2, "R9 cancel"); send(8'hF6, "R9 cancel"); drain("R9 cancel"); rd("R9 cancel");

    send(8'hF8, "R10"); send(8'hFB, "R10"); send(8'hED, "R10"); send(8'h02, "R10"); drain("R10");
    send(8'hFD, "R10"); send(8'h77, "R10"); drain("R10");

    send(8'hFE, "R11"); drain("R11");
    send(8'hEE, "R11"); step(1'b1, 8'hFE, 1'b1, "R11 same"); drain("R11");

    rd("R12 empty pop");
    for (int i = 0; i < DEPTH + 2; i++) send(8'hF7, "R12 fill");
    drain("R12"); rd("R12 empty");
    send(8'hFF, "R12"); rd("R12"); rd("R12 empty");
    for (int i = 0; i < DEPTH; i++) send(8'hF9, "R12 full");
    send(8'hEE, "R12 drop"); drain("R12");

    send(8'hF2, "R13"); step(1'b1, 8'hEE, 1'b1, "R13 same"); drain("R13");
    send(8'hFF, "R13"); send(8'hF0, "R13");
    step(1'b1, 8'h00, 1'b1, "R13 query"); drain("R13");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule